// File: doc/BRIEF.md
# Electrical Idle Inference Unit

This block produces the electrical-idle flag that a PCIe receiver lane hands to its link layer through a PIPE-style interface. A 3-bit select code and a static enable choose where that flag comes from. The first source is a sticky flag that an electrical idle ordered set pulse sets. The second source is a timeout that depends on the training state. When inference is off, the flag is the inverted analog signal-detect level.

The timeout source has two variants. In the first, the lane sits in Recovery.Speed after a failed speed change, and the window is 2000 UI. That window is counted as symbol strobes at 10 UI per symbol. In the second, the lane is a loopback slave in Loopback.Active, and the window is 128 µs. That window is counted in clock cycles derived from a clock-frequency parameter. Only the signal-detect level counts as an exit from idle. No ordered set, symbol strobe or idle pulse ever ends or restarts a window. The training state machine, ordered-set decoding and squelch detection all sit outside the block.

Top module: `eidle_infer_unit`

## Requirements
- R1: After reset, all internal idle flags are 0. With inference enabled and select 3'b000, `eidle_o` reads 0 until the first ordered-set pulse.
- R2: With `infer_en_i` = 0, `eidle_o` equals `!sig_det_i` in the same cycle, whatever the select code.
- R3: With inference enabled and select 3'b0xx, `eidle_o` goes high at the clock edge that samples `eios_det_i` = 1. It stays high until an edge that samples `sig_det_i` = 1 with `eios_det_i` = 0. When both inputs are 1 at the same edge, the flag is set.
- R4: With inference enabled and select 3'b100 or 3'b101, `eidle_o` equals `!sig_det_i` in the same cycle.
- R5: With inference enabled and select 3'b110, `eidle_o` rises at the edge of the 200th `sym_valid_i` strobe. Only strobes count that are sampled while `state_i` = 4'h6 (Recovery.Speed after failed negotiation) and `sig_det_i` = 0.
- R6: With inference enabled and select 3'b111, `eidle_o` rises at the 16000th consecutive clock edge that samples `state_i` = 4'hA (Loopback.Active as slave) and `sig_det_i` = 0. The count is 125 cycles per µs times 128 µs at the default parameters.
- R7: Any edge that samples `sig_det_i` = 1 restarts both timeout windows and clears both inferred flags. This holds even when that edge carries the final strobe of a window.
- R8: An edge that samples a state other than the qualifying one restarts that window. An inferred flag that is already set stays set until signal detect returns.
- R9: `eios_det_i` pulses neither restart nor end a timeout window. They do not change `eidle_o` while select is 3'b110 or 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Inference select code |
| infer_en_i | input | 1 | Static inference enable |
| eios_det_i | input | 1 | One-cycle pulse on a received idle ordered set |
| sig_det_i | input | 1 | Analog signal-detect level, 1 = signal present |
| state_i | input | 4 | Current training-state code |
| sym_valid_i | input | 1 | One-cycle strobe per received symbol |
| eidle_o | output | 1 | Electrical-idle flag |

## Verification
Two events can fall on the same edge. An ordered-set pulse can coincide with a signal-detect assertion, and the last strobe of a timeout window can coincide with signal detect returning. The bench provokes the first with a single cycle in which both inputs are high. It provokes the second by feeding exactly 199 strobes and then one strobe together with signal detect. The behavioural model expects idle to be set in the first case and the window to restart with no flag in the second. Both results are also checked directly at the port on the following cycles.

// File: rtl/eii_pkg.sv
package eii_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_EIOS = 2'd1,
    MODE_RS   = 2'd2,
    MODE_LB   = 2'd3
  } eii_mode_e;
endpackage

// File: rtl/eii_mode_dec.sv
module eii_mode_dec
  import eii_pkg::*;
(
  input  logic       infer_en_i,
  input  logic [2:0] sel_i,
  output eii_mode_e  mode_o
);
  always_comb begin
    if (!infer_en_i)      mode_o = MODE_OFF;
    else if (!sel_i[2])   mode_o = MODE_EIOS;
    else begin
      unique case (sel_i[1:0])
        2'b10:   mode_o = MODE_RS;
        2'b11:   mode_o = MODE_LB;
        default: mode_o = MODE_OFF;
      endcase
    end
  end
endmodule

// File: rtl/eii_eios_track.sv
module eii_eios_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eios_det_i,
  input  logic sig_det_i,
  output logic flag_o
);
  logic flag_q;

  // set has priority over a coincident exit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (eios_det_i) flag_q <= 1'b1;
    else if (sig_det_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R3
  eios_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eios_det_i |=> flag_q);
  // R3
  eios_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !sig_det_i) |=> flag_q);
endmodule

// File: rtl/eii_idle_timer.sv
module eii_idle_timer #(
  parameter int unsigned         LIMIT      = 200,
  parameter int unsigned         STATE_W    = 4,
  parameter logic [STATE_W-1:0]  STATE_CODE = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STATE_W-1:0] state_i,
  input  logic               sig_det_i,
  input  logic               tick_i,
  output logic               flag_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic          in_state;

  assign in_state = (state_i == STATE_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (sig_det_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (!in_state || flag_q) begin
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        flag_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign flag_o = flag_q;

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R7
  exit_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_det_i |=> (!flag_q && cnt_q == '0));
  // R8
  leave_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_state && !sig_det_i) |=> (cnt_q == '0 && flag_q == $past(flag_q)));
  // R6
  rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(tick_i && in_state && !sig_det_i));
endmodule

// File: rtl/eidle_infer_unit.sv
module eidle_infer_unit
  import eii_pkg::*;
#(
  parameter int unsigned        UI_WIN     = 2000,
  parameter int unsigned        UI_PER_SYM = 10,
  parameter int unsigned        CLK_MHZ    = 125,
  parameter int unsigned        LB_US      = 128,
  parameter int unsigned        STATE_W    = 4,
  parameter logic [STATE_W-1:0] RS_CODE    = 4'h6,
  parameter logic [STATE_W-1:0] LB_CODE    = 4'hA
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         sel_i,
  input  logic               infer_en_i,
  input  logic               eios_det_i,
  input  logic               sig_det_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic               sym_valid_i,
  output logic               eidle_o
);
  localparam int unsigned RS_SYMS = UI_WIN / UI_PER_SYM;
  localparam int unsigned LB_CYC  = CLK_MHZ * LB_US;

  eii_mode_e mode;
  logic      eios_flag, rs_flag, lb_flag;

  eii_mode_dec i_dec (
    .infer_en_i (infer_en_i),
    .sel_i      (sel_i),
    .mode_o     (mode)
  );

  eii_eios_track i_eios (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eios_det_i (eios_det_i),
    .sig_det_i  (sig_det_i),
    .flag_o     (eios_flag)
  );

  // strobe-counted window
  eii_idle_timer #(
    .LIMIT(RS_SYMS), .STATE_W(STATE_W), .STATE_CODE(RS_CODE)
  ) i_rs_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state_i),
    .sig_det_i (sig_det_i),
    .tick_i    (sym_valid_i),
    .flag_o    (rs_flag)
  );

  // cycle-counted window
  eii_idle_timer #(
    .LIMIT(LB_CYC), .STATE_W(STATE_W), .STATE_CODE(LB_CODE)
  ) i_lb_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state_i),
    .sig_det_i (sig_det_i),
    .tick_i    (1'b1),
    .flag_o    (lb_flag)
  );

  always_comb begin
    unique case (mode)
      MODE_EIOS: eidle_o = eios_flag;
      MODE_RS:   eidle_o = rs_flag;
      MODE_LB:   eidle_o = lb_flag;
      default:   eidle_o = !sig_det_i;
    endcase
  end

  // R9
  rs_eios_blind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_RS && $past(mode == MODE_RS) && !sig_det_i && !$past(sig_det_i)
     && $past(state_i != RS_CODE)) |-> eidle_o == $past(eidle_o));
endmodule

// File: tb/test_eidle_infer_unit.sv
module test_eidle_infer_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic       en = 1'b1;
  logic       eios = 1'b0;
  logic       sd = 1'b0;
  logic [3:0] st = 4'h0;
  logic       sv = 1'b0;
  logic       eidle;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit run_cmp = 1'b0;

  localparam int RS_N = 200;
  localparam int LB_N = 125 * 128;

  always #4 clk = ~clk;

  eidle_infer_unit i_eidle_infer_unit (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .infer_en_i(en),
    .eios_det_i(eios), .sig_det_i(sd), .state_i(st),
    .sym_valid_i(sv), .eidle_o(eidle)
  );

  // behavioural reference
  bit m_eios, m_rs, m_lb;
  int c_rs, c_lb;

  function automatic bit expect_out();
    if (!en) return !sd;
    if (!sel[2]) return m_eios;
    if (sel == 3'b110) return m_rs;
    if (sel == 3'b111) return m_lb;
    return !sd;
  endfunction

  function automatic string tag_of();
    if (!en) return "R2";
    if (!sel[2]) return "R3";
    if (sel == 3'b110) return "R5";
    if (sel == 3'b111) return "R6";
    return "R4";
  endfunction

  task automatic chk(input bit got, input bit exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: eidle_o=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_eios = 0; m_rs = 0; m_lb = 0; c_rs = 0; c_lb = 0;
    end else begin
      if (eios) m_eios = 1; else if (sd) m_eios = 0;
      if (sd) begin m_rs = 0; c_rs = 0; end
      else if (st != 4'h6 || m_rs) c_rs = 0;
      else if (sv) begin c_rs++; if (c_rs == RS_N) begin m_rs = 1; c_rs = 0; end end
      if (sd) begin m_lb = 0; c_lb = 0; end
      else if (st != 4'hA || m_lb) c_lb = 0;
      else begin c_lb++; if (c_lb == LB_N) begin m_lb = 1; c_lb = 0; end end
    end
    #2;
    if (rst_n && run_cmp) chk(eidle, expect_out(), tag_of());
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: expired expected completion");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    chk(eidle, 1'b0, "R1");
    rst_n = 1'b1;
    cyc(1);
    chk(eidle, 1'b0, "R1");
    run_cmp = 1'b1;

    // R2: disabled path, any select
    en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      sel = 3'($urandom); sd = 1'($urandom); eios = 1'($urandom);
      #1 chk(eidle, !sd, "R2");
      cyc(1);
    end
    eios = 0; en = 1'b1;

    // R3: idle ordered-set path
    sel = 3'b010; sd = 1'b0; cyc(2);
    eios = 1'b1; cyc(1); eios = 1'b0;
    chk(eidle, 1'b1, "R3");
    cyc(5);
    sd = 1'b1; cyc(1);
    chk(eidle, 1'b0, "R3");
    eios = 1'b1; cyc(1); eios = 1'b0; // collision: set wins
    chk(eidle, 1'b1, "R3");
    cyc(1);
    chk(eidle, 1'b0, "R3");
    for (int i = 0; i < 60; i++) begin
      sel = {1'b0, 2'($urandom)};
      eios = ($urandom % 5) == 0; sd = ($urandom % 4) == 0;
      cyc(1);
    end
    eios = 1'b0;

    // R4: other 1xx codes
    for (int i = 0; i < 40; i++) begin
      sel = {2'b10, 1'($urandom)}; sd = 1'($urandom);
      #1 chk(eidle, !sd, "R4");
      cyc(1);
    end

    // R5/R7: strobe window with exit on the last strobe
    sel = 3'b110; st = 4'h6; sd = 1'b1; cyc(1);
    sd = 1'b0; sv = 1'b1; cyc(199);
    sd = 1'b1; cyc(1);
    sd = 1'b0; sv = 1'b0; cyc(1);
    chk(eidle, 1'b0, "R7");
    sv = 1'b1; cyc(199);
    chk(eidle, 1'b0, "R5");
    cyc(1);
    chk(eidle, 1'b1, "R5");
    sv = 1'b0; sd = 1'b1; cyc(1);
    chk(eidle, 1'b0, "R7");
    sd = 1'b0;
    // R9: ordered-set pulses during counting
    for (int i = 0; i < 700; i++) begin
      sv = 1'($urandom); eios = ($urandom % 7) == 0;
      cyc(1);
    end
    eios = 1'b0;
    // R8: leave state with flag high and mid-window
    st = 4'h3; cyc(3);
    chk(eidle, 1'b1, "R8");
    sd = 1'b1; cyc(1); sd = 1'b0; st = 4'h6;
    sv = 1'b1; cyc(150); st = 4'h2; cyc(1); st = 4'h6; cyc(150);
    chk(eidle, 1'b0, "R8");
    cyc(60);
    sv = 1'b0;

    // R6: cycle window, interrupted, left, then full
    sel = 3'b111; st = 4'hA; sd = 1'b1; cyc(1); sd = 1'b0;
    cyc(9000); sd = 1'b1; cyc(1); sd = 1'b0;
    cyc(8000); st = 4'h1; cyc(1); st = 4'hA;
    cyc(LB_N - 1);
    chk(eidle, 1'b0, "R6");
    cyc(1);
    chk(eidle, 1'b1, "R6");
    eios = 1'b1; cyc(1); eios = 1'b0;
    chk(eidle, 1'b1, "R9");
    st = 4'h0; cyc(20);
    chk(eidle, 1'b1, "R8");
    sd = 1'b1; cyc(1);
    chk(eidle, 1'b0, "R7");
    cyc(5);

    done = 1'b1;
    run_cmp = 1'b0;
    finish_run();
  end
endmodule